// File: doc/BRIEF.md
# Three-Input Lookup Table with Dual-Path Configuration Loader

This block is a single programmable logic primitive. Eight storage cells hold a truth table with one bit per input combination. Three logic inputs form a binary index, and a multiplexer puts the selected cell on a combinational output. With the right table loaded, the block therefore computes any Boolean function of three variables.

The table can be loaded in two ways, chosen by a mode pin. In addressed mode, a decoder turns a 3-bit address into a one-hot cell select, and a write strobe loads one cell per clock. Any single cell can be changed this way while the other seven keep their contents. In serial mode, the eight cells form a shift chain fed by one data pin. Eight enabled clocks replace the whole table, with the bit for cell 7 sent first.

A small per-cycle controller turns the mode and the two strobes into one of three named actions. HOLD leaves the table unchanged. SHIFT advances the chain. WRITE loads the addressed cell. A new action is chosen on every clock, based only on the current pins, and there are no transitions that carry history. The mode pin decides which strobe is honoured. In serial mode, SHIFT is chosen when the shift enable is high, and the write strobe is ignored. In addressed mode, WRITE is chosen when the write enable is high, and the shift enable is ignored. HOLD is chosen whenever the armed strobe is low.

Top module: `cfg_lut3`

## Requirements
- R1: A synchronous reset clears all eight cells to 0, so the output is 0 for every input combination afterwards.
- R2: The output equals the cell whose index is {sel[2], sel[1], sel[0]}, with sel[2] as the most significant bit (sel = 3'b101 reads cell 5). It follows a change of `sel` with no clock edge.
- R3: With `cfg_mode` = 0 and `wr_en` = 1, the clock edge stores `wr_data` into the cell numbered `wr_addr`, and the other seven cells are unchanged.
- R4: Eight addressed writes, one per clock, load an arbitrary complete truth table.
- R5: With `cfg_mode` = 1 and `shift_en` = 1, each clock edge moves cell i into cell i+1 and loads `ser_din` into cell 0. After eight shifts, the first bit sent sits in cell 7 and the last bit sent sits in cell 0.
- R6: With `cfg_mode` = 1, `wr_en` has no effect. If `shift_en` is high in the same cycle, only the shift takes place.
- R7: With `cfg_mode` = 0, `shift_en` and `ser_din` have no effect on the table.
- R8: When the strobe armed by the current mode is low, the table holds its contents.
- R9: A configuration change reaches the output only after the clock edge that stores it. Before that edge, the output still shows the old cell value.
- R10: After the function A'B'C' + AB'C + ABC is loaded (A = sel[2]), the output is 1 exactly for sel = 0, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all cell updates happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the table |
| cfg_mode | input | 1 | Loader select: 0 = addressed, 1 = serial |
| ser_din | input | 1 | Serial configuration bit entering cell 0 |
| shift_en | input | 1 | Advance the shift chain (serial mode only) |
| wr_addr | input | 3 | Cell number for an addressed write |
| wr_data | input | 1 | Bit stored by an addressed write |
| wr_en | input | 1 | Addressed write strobe (addressed mode only) |
| sel | input | 3 | Logic inputs; sel[2] is A, sel[0] is C |
| lut_out | output | 1 | Combinational value of the selected cell |

## Verification
The hardest cases to reach are cycles where both strobes are high at once, or where the strobe that is not armed in the current mode is pulsed. A wrong priority there leaves no mark unless the table is read back in full afterwards. The stimulus therefore raises both enables together in serial mode, with write data that differs from the shifted bit. It also pulses the disarmed strobe in each mode, and then sweeps all eight `sel` values through the scoreboard. The update-after-edge case is checked by holding `sel` on the cell being written and sampling the output both before and after the storing edge.

// File: rtl/cfg_lut3_pkg.sv
package cfg_lut3_pkg;

    localparam int unsigned LUT_INPUTS = 3;

    typedef enum logic {
        MODE_ADDR   = 1'b0,
        MODE_SERIAL = 1'b1
    } cfg_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_WRITE = 2'd2
    } cfg_act_e;

endpackage

// File: rtl/cfg_lut3_ctrl.sv
module cfg_lut3_ctrl
    import cfg_lut3_pkg::*;
(
    input  logic     cfg_mode,
    input  logic     shift_en,
    input  logic     wr_en,
    output cfg_act_e act
);

    always_comb begin
        act = ACT_HOLD;
        unique case (cfg_mode_e'(cfg_mode))
            MODE_SERIAL: if (shift_en) act = ACT_SHIFT;
            MODE_ADDR:   if (wr_en)    act = ACT_WRITE;
            default:     act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/cfg_lut3_store.sv
module cfg_lut3_store
    import cfg_lut3_pkg::*;
#(
    parameter int unsigned N_IN = LUT_INPUTS,
    localparam int unsigned DEPTH = 1 << N_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_act_e         act,
    input  logic             ser_din,
    input  logic [N_IN-1:0]  wr_addr,
    input  logic             wr_data,
    output logic [DEPTH-1:0] wsel,
    output logic [DEPTH-1:0] cells_q
);

    logic [DEPTH-1:0] chain_in;
    logic [DEPTH-1:0] cells_d;

    assign chain_in = {cells_q[DEPTH-2:0], ser_din};

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign wsel[i] = (act == ACT_WRITE) && (wr_addr == N_IN'(i));

        always_comb begin
            cells_d[i] = cells_q[i];
            unique case (act)
                ACT_SHIFT: cells_d[i] = chain_in[i];
                ACT_WRITE: if (wsel[i]) cells_d[i] = wr_data;
                default:   cells_d[i] = cells_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
        end else begin
            cells_q <= cells_d;
        end
    end

endmodule

// File: rtl/cfg_lut3_mux.sv
module cfg_lut3_mux #(
    parameter int unsigned N_IN = 3,
    localparam int unsigned DEPTH = 1 << N_IN
) (
    input  logic [DEPTH-1:0] table_bits,
    input  logic [N_IN-1:0]  idx,
    output logic             y
);

    assign y = table_bits[idx];

endmodule

// File: rtl/cfg_lut3.sv
module cfg_lut3
    import cfg_lut3_pkg::*;
#(
    parameter int unsigned N_IN = LUT_INPUTS,
    localparam int unsigned DEPTH = 1 << N_IN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_mode,
    input  logic            ser_din,
    input  logic            shift_en,
    input  logic [N_IN-1:0] wr_addr,
    input  logic            wr_data,
    input  logic            wr_en,
    input  logic [N_IN-1:0] sel,
    output logic            lut_out
);

    cfg_act_e         act;
    logic [DEPTH-1:0] wsel;
    logic [DEPTH-1:0] cells;

    cfg_lut3_ctrl u_ctrl (
        .cfg_mode (cfg_mode),
        .shift_en (shift_en),
        .wr_en    (wr_en),
        .act      (act)
    );

    cfg_lut3_store #(.N_IN(N_IN)) u_store (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .ser_din (ser_din),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wsel    (wsel),
        .cells_q (cells)
    );

    cfg_lut3_mux #(.N_IN(N_IN)) u_mux (
        .table_bits (cells),
        .idx        (sel),
        .y          (lut_out)
    );

endmodule

// File: rtl/cfg_lut3_chk.sv
module cfg_lut3_chk #(
    parameter int unsigned N_IN = 3,
    localparam int unsigned DEPTH = 1 << N_IN
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_mode,
    input logic             ser_din,
    input logic             shift_en,
    input logic [N_IN-1:0]  wr_addr,
    input logic             wr_data,
    input logic             wr_en,
    input logic [N_IN-1:0]  sel,
    input logic             lut_out,
    input logic [DEPTH-1:0] cells,
    input logic [DEPTH-1:0] wsel
);

    logic [DEPTH-1:0] addr_mask;
    assign addr_mask = DEPTH'(1) << wr_addr;

    // R1: the cycle after reset the table is empty
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (cells == '0));

    // R2: output reflects the selected cell
    a_r2_read_select: assert property (@(posedge clk) disable iff (rst)
        lut_out == cells[sel]);

    // R3: addressed write hits one cell only
    a_r3_addr_write: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && wr_en) |=>
            (cells[$past(wr_addr)] == $past(wr_data)) &&
            ((cells & ~$past(addr_mask)) == ($past(cells) & ~$past(addr_mask))));

    // R3: decoder select is never more than one cell
    a_r3_decode_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wsel));

    // R5, R6: shift moves the chain up by one, write strobe ignored
    a_r5_shift_chain: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && shift_en) |=>
            (cells == {$past(cells[DEPTH-2:0]), $past(ser_din)}));

    // R6: no decoder activity in serial mode
    a_r6_no_write_serial: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> (wsel == '0));

    // R7, R8: table holds when the armed strobe is low
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        ((cfg_mode && !shift_en) || (!cfg_mode && !wr_en)) |=> $stable(cells));

endmodule

bind cfg_lut3 cfg_lut3_chk #(.N_IN(N_IN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_mode (cfg_mode),
    .ser_din  (ser_din),
    .shift_en (shift_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .sel      (sel),
    .lut_out  (lut_out),
    .cells    (cells),
    .wsel     (wsel)
);

// File: tb/cfg_lut3_tb.sv
module cfg_lut3_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_mode = 1'b0;
    logic       ser_din = 1'b0;
    logic       shift_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic       wr_data = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] sel = '0;
    logic       lut_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model = '0;

    typedef struct {
        logic       exp;
        logic [2:0] idx;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    cfg_lut3 u_dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .ser_din  (ser_din),
        .shift_en (shift_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .sel      (sel),
        .lut_out  (lut_out)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // monitor: pop expected items and compare against the output
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, lut_out, it.exp, $sformatf("sel=%0d", it.idx));
            end
        end
    end

    // driver: sweep every input combination, pushing the model value
    task automatic sweep(input string tag);
        for (int i = 0; i < 8; i++) begin
            sb_item_t it;
            @(posedge clk);
            #1;
            sel = 3'(i);
            it.exp = model[i];
            it.idx = 3'(i);
            it.tag = tag;
            sb_q.push_back(it);
        end
        @(negedge clk);
        #1;
    endtask

    task automatic addr_write(input logic [2:0] a, input logic d);
        @(posedge clk);
        #1;
        cfg_mode = 1'b0; wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model[a] = d;
    endtask

    task automatic shift_bit(input logic b, input logic also_wr);
        @(posedge clk);
        #1;
        cfg_mode = 1'b1; ser_din = b; shift_en = 1'b1;
        wr_en = also_wr; wr_addr = 3'd0; wr_data = ~b;
        @(posedge clk);
        #1;
        shift_en = 1'b0; wr_en = 1'b0;
        model = {model[6:0], b};
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        model = '0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] stream;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: empty table after reset
        sweep("R1");

        // R4 / R10: load A'B'C' + AB'C + ABC by addressed writes
        for (int i = 0; i < 8; i++) begin
            addr_write(3'(i), (i == 0) || (i == 5) || (i == 7));
        end
        sweep("R10");
        check("R2", model[5], 1'b1, "cell5 for ABC=101");

        // R3: rewrite one cell, others intact
        addr_write(3'd2, 1'b1);
        sweep("R3");

        // R9: write visible only after the storing edge
        @(posedge clk);
        #1;
        sel = 3'd3;
        cfg_mode = 1'b0; wr_addr = 3'd3; wr_data = 1'b1; wr_en = 1'b1;
        #2;
        check("R9", lut_out, 1'b0, "before edge");
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model[3] = 1'b1;
        check("R9", lut_out, 1'b1, "after edge");

        // R7: shift strobe in addressed mode ignored
        @(posedge clk);
        #1;
        cfg_mode = 1'b0; shift_en = 1'b1; ser_din = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        shift_en = 1'b0;
        sweep("R7");

        // R8: idle cycles in both modes
        cfg_mode = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        cfg_mode = 1'b0;
        sweep("R8");

        // R4: a second full addressed load with a different table
        for (int i = 0; i < 8; i++) begin
            addr_write(3'(i), ((8'h3C >> i) & 8'h1) != 0);
        end
        sweep("R4");

        // R5: serial load, cell 7 bit first
        stream = 8'h96;
        for (int i = 7; i >= 0; i--) begin
            shift_bit(stream[i], 1'b0);
        end
        check("R5", (model == 8'h96) ? 1'b1 : 1'b0, 1'b1, "model order");
        sweep("R5");

        // R6: shift and write together in serial mode, shift wins
        shift_bit(1'b0, 1'b1);
        sweep("R6");

        // R6: write strobe alone in serial mode ignored
        @(posedge clk);
        #1;
        cfg_mode = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = ~model[0];
        repeat (2) @(posedge clk);
        #1;
        wr_en = 1'b0;
        sweep("R6");

        // R2: combinational response to sel mid-cycle
        @(posedge clk);
        #1;
        sel = 3'd1;
        #1;
        check("R2", lut_out, model[1], "sel=1 mid-cycle");
        sel = 3'd7;
        #1;
        check("R2", lut_out, model[7], "sel=7 mid-cycle");

        // R1: reset after a loaded table
        do_reset();
        sweep("R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule